// File: doc/BRIEF.md
# Slow Clock Detector with Programmable Timebase

The block decides whether a measured clock runs at least twice as fast as a gate clock whose period is picked from a programmable timebase. A fast reference clock drives every register. The measured clock is chosen from an internal and an external input. It is synchronized into the reference domain, and its rising edges are counted over each gate window. A window that holds fewer than two edges marks the measured clock as slow. The slow flag then stays set until the host acknowledges it.

A free-running timer raises a maskable interrupt at a fixed interval that stands for 100 ms. At each interrupt the host reads the slow flag and acknowledges it. The acknowledge clears the flag and the interrupt and starts a fresh window. A small write-only register port sets the clock source, the gate range and the interrupt mask. Two parameters shorten the long ranges and the timer interval in simulation without changing the logic: the reference period in ns and a time-scale divisor.

Top module: `clk_slow_detect`

## Requirements
- R1: A range write (address 0x2, data bits [3:0]) picks the gate window from codes 0..9, meaning 20 ns, 50 ns, 100 ns, 200 ns, 500 ns, 1 us, 100 us, 1 ms, 10 ms and 1 s. The window lasts period/REF_NS reference cycles. For the codes of 100 us and longer the count is further divided by TIME_DIV. A window is never shorter than 1 cycle. Range code 0 is selected after reset.
- R2: A window that ends with two or more synchronized rising edges of the measured clock leaves the slow flag unchanged.
- R3: A window that ends with fewer than two rising edges sets the slow flag on the clock edge that closes the window.
- R4: The slow flag is sticky until an acknowledge write (address 0x4, any data). That write clears the flag and the pending interrupt and restarts the window, all on the same clock edge.
- R5: The timer sets the interrupt pending bit every 100_000_000/(REF_NS*TIME_DIV) reference cycles. The timer is free running, so acknowledges do not shift its phase.
- R6: The interrupt is masked after reset. A write to address 0x3 with bit 0 = 1 unmasks it, and bit 0 = 0 masks it again. The interrupt output is pending AND unmasked.
- R7: A source write (address 0x1, 6 data bits) equal to binary 111110 selects the internal clock input. Any other value selects the external input, which is the reset choice. Every source write restarts the window.
- R8: An accepted range write restarts the gate window and drops the edges counted so far. A window that never completes is never reported.
- R9: A range write whose data bits [3:0] hold 10..15 is ignored, and the previous range stays in force.
- R10: After reset the slow flag and the interrupt output are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref_i | input | 1 | Fast reference clock, rising edge active |
| rst_n_i | input | 1 | Active-low reset, synchronous to clk_ref_i |
| int_clk_i | input | 1 | Internal clock to be measured |
| ext_clk_i | input | 1 | External clock to be measured |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| wr_addr_i | input | ADDR_W (4) | Register address |
| wr_data_i | input | DATA_W (6) | Register write data |
| slow_flag_o | output | 1 | Sticky slow-clock flag |
| irq_o | output | 1 | Timer interrupt, pending and unmasked |

## Verification
The hardest case to reach from the ports is a partial window being thrown away. The flag can only show that a window was dropped if a stopped clock would otherwise have set it within one timer interval. The bench therefore stops the measured clock under a 100-cycle window and rewrites the same range every 60 cycles for longer than a timer interval; the flag must read clear at the interrupt. A 1 s range, scaled to a window longer than the timer interval, checks in the same way that an unfinished window never reaches the flag.

// File: rtl/scd_pkg.sv
`timescale 1ns/1ps
package scd_pkg;
  localparam int unsigned NUM_RANGES      = 10;
  localparam int unsigned RANGE_W         = 4;
  localparam int unsigned SRC_W           = 6;
  localparam int unsigned SLOW_EDGE_LIMIT = 2;
  localparam int unsigned UNSCALED_MAX_NS = 1000;
  localparam int unsigned TIMER_NS        = 100_000_000;

  localparam logic [SRC_W-1:0] SRC_INTERNAL = 6'b111110;

  localparam int unsigned ADDR_SRC   = 1;
  localparam int unsigned ADDR_RANGE = 2;
  localparam int unsigned ADDR_CTRL  = 3;
  localparam int unsigned ADDR_ACK   = 4;

  // gate period of each range code, in ns
  function automatic int unsigned range_ns(input int unsigned code);
    case (code)
      0:       return 20;
      1:       return 50;
      2:       return 100;
      3:       return 200;
      4:       return 500;
      5:       return 1_000;
      6:       return 100_000;
      7:       return 1_000_000;
      8:       return 10_000_000;
      9:       return 1_000_000_000;
      default: return 0;
    endcase
  endfunction

  function automatic int unsigned to_cycles(input int unsigned ns, input int unsigned ref_ns,
                                            input int unsigned div, input bit scaled);
    int unsigned c;
    c = ns / ref_ns;
    if (scaled) c = c / div;
    if (c == 0) c = 1;
    return c;
  endfunction

  function automatic int unsigned gate_cycles(input int unsigned code, input int unsigned ref_ns,
                                              input int unsigned div);
    return to_cycles(range_ns(code), ref_ns, div, range_ns(code) > UNSCALED_MAX_NS);
  endfunction

  function automatic int unsigned timer_cycles(input int unsigned ref_ns, input int unsigned div);
    return to_cycles(TIMER_NS, ref_ns, div, 1'b1);
  endfunction

  function automatic logic range_valid(input logic [RANGE_W-1:0] code);
    return code < RANGE_W'(NUM_RANGES);
  endfunction

  // a window is slow when stored edges plus the edge of the closing cycle stay under the limit
  function automatic logic window_is_slow(input logic [1:0] cnt, input logic edge_now);
    return ({1'b0, cnt} + {2'b00, edge_now}) < 3'(SLOW_EDGE_LIMIT);
  endfunction
endpackage

// File: rtl/scd_regs.sv
`timescale 1ns/1ps
module scd_regs
  import scd_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [SRC_W-1:0]   src_sel,
  output logic [RANGE_W-1:0] range_code,
  output logic               unmask,
  output logic               ack_pulse,
  output logic               ctrl_wr,
  output logic               cfg_restart
);
  logic wr_src, wr_range, range_ok;

  assign wr_src      = wr_en && (wr_addr == ADDR_W'(ADDR_SRC));
  assign wr_range    = wr_en && (wr_addr == ADDR_W'(ADDR_RANGE));
  assign ctrl_wr     = wr_en && (wr_addr == ADDR_W'(ADDR_CTRL));
  assign ack_pulse   = wr_en && (wr_addr == ADDR_W'(ADDR_ACK));
  assign range_ok    = range_valid(wr_data[RANGE_W-1:0]);
  assign cfg_restart = wr_src || (wr_range && range_ok);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_sel    <= '0;
      range_code <= '0;
      unmask     <= 1'b0;
    end else begin
      if (wr_src)               src_sel    <= wr_data[SRC_W-1:0];
      if (wr_range && range_ok) range_code <= wr_data[RANGE_W-1:0];
      if (ctrl_wr)              unmask     <= wr_data[0];
    end
  end

  p_range_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    range_code < RANGE_W'(NUM_RANGES));

  p_invalid_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_range && (wr_data[RANGE_W-1:0] >= RANGE_W'(NUM_RANGES))) |=> $stable(range_code));
endmodule

// File: rtl/scd_timebase.sv
`timescale 1ns/1ps
module scd_timebase
  import scd_pkg::*;
#(
  parameter int unsigned REF_NS   = 10,
  parameter int unsigned TIME_DIV = 1,
  parameter int unsigned CNT_W    = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RANGE_W-1:0] range_code,
  input  logic               restart,
  output logic               win_end
);
  logic [CNT_W-1:0] len_lut [NUM_RANGES];
  logic [CNT_W-1:0] cur_len;
  logic [CNT_W-1:0] gcnt;

  for (genvar g = 0; g < NUM_RANGES; g++) begin : g_len
    localparam int unsigned LEN = gate_cycles(g, REF_NS, TIME_DIV);
    assign len_lut[g] = CNT_W'(LEN);
  end

  always_comb begin
    cur_len = CNT_W'(1);
    for (int i = 0; i < NUM_RANGES; i++)
      if (range_code == RANGE_W'(i)) cur_len = len_lut[i];
  end

  assign win_end = !restart && (gcnt >= cur_len - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)                gcnt <= '0;
    else if (restart || win_end) gcnt <= '0;
    else                       gcnt <= gcnt + CNT_W'(1);
  end

  p_window_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    gcnt < cur_len);

  p_restart_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (gcnt == '0));
endmodule

// File: rtl/scd_edge_meter.sv
`timescale 1ns/1ps
module scd_edge_meter
  import scd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic meas_clk,
  input  logic win_end,
  input  logic restart,
  input  logic ack,
  output logic slow_flag
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   rise;
  logic [1:0]             ecnt;
  logic                   few;

  assign rise = sync_q[SYNC_STAGES-1] && !prev_q;
  assign few  = window_is_slow(ecnt, rise);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], meas_clk};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                            ecnt <= '0;
    else if (restart || win_end)           ecnt <= '0;
    else if (rise && (ecnt != 2'd2))       ecnt <= ecnt + 2'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              slow_flag <= 1'b0;
    else if (ack)            slow_flag <= 1'b0;
    else if (win_end && few) slow_flag <= 1'b1;
  end

  p_fast_window_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!slow_flag && win_end && !few) |=> !slow_flag);

  p_slow_window_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && few && !ack) |=> slow_flag);

  p_flag_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_flag && !ack) |=> slow_flag);

  p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !slow_flag);
endmodule

// File: rtl/scd_timer.sv
`timescale 1ns/1ps
module scd_timer
  import scd_pkg::*;
#(
  parameter int unsigned REF_NS   = 10,
  parameter int unsigned TIME_DIV = 1,
  parameter int unsigned CNT_W    = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack,
  output logic tick,
  output logic pend
);
  localparam logic [CNT_W-1:0] TLAST = CNT_W'(timer_cycles(REF_NS, TIME_DIV) - 1);

  logic [CNT_W-1:0] tcnt;

  assign tick = (tcnt == TLAST);

  always_ff @(posedge clk) begin
    if (!rst_n)    tcnt <= '0;
    else if (tick) tcnt <= '0;
    else           tcnt <= tcnt + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    pend <= 1'b0;
    else if (tick) pend <= 1'b1;
    else if (ack)  pend <= 1'b0;
  end

  p_tick_sets_pend_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (pend && (tcnt == '0)));

  p_count_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tcnt <= TLAST);
endmodule

// File: rtl/clk_slow_detect.sv
`timescale 1ns/1ps
module clk_slow_detect
  import scd_pkg::*;
#(
  parameter int unsigned REF_NS      = 10,
  parameter int unsigned TIME_DIV    = 1,
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned DATA_W      = 6
) (
  input  logic              clk_ref_i,
  input  logic              rst_n_i,
  input  logic              int_clk_i,
  input  logic              ext_clk_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              slow_flag_o,
  output logic              irq_o
);
  logic [SRC_W-1:0]   src_sel;
  logic [RANGE_W-1:0] range_code;
  logic               unmask, ack_pulse, ctrl_wr, cfg_restart;
  logic               restart, win_end, meas_clk, tick, pend;

  scd_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk_ref_i), .rst_n(rst_n_i), .wr_en(wr_en_i), .wr_addr(wr_addr_i),
    .wr_data(wr_data_i), .src_sel(src_sel), .range_code(range_code), .unmask(unmask),
    .ack_pulse(ack_pulse), .ctrl_wr(ctrl_wr), .cfg_restart(cfg_restart));

  assign restart  = cfg_restart || ack_pulse;
  assign meas_clk = (src_sel == SRC_INTERNAL) ? int_clk_i : ext_clk_i;

  scd_timebase #(.REF_NS(REF_NS), .TIME_DIV(TIME_DIV), .CNT_W(CNT_W)) u_timebase (
    .clk(clk_ref_i), .rst_n(rst_n_i), .range_code(range_code), .restart(restart),
    .win_end(win_end));

  scd_edge_meter #(.SYNC_STAGES(SYNC_STAGES)) u_meter (
    .clk(clk_ref_i), .rst_n(rst_n_i), .meas_clk(meas_clk), .win_end(win_end),
    .restart(restart), .ack(ack_pulse), .slow_flag(slow_flag_o));

  scd_timer #(.REF_NS(REF_NS), .TIME_DIV(TIME_DIV), .CNT_W(CNT_W)) u_timer (
    .clk(clk_ref_i), .rst_n(rst_n_i), .ack(ack_pulse), .tick(tick), .pend(pend));

  assign irq_o = pend && unmask;

  p_tick_raises_irq_r6: assert property (@(posedge clk_ref_i) disable iff (!rst_n_i)
    (tick && unmask && !ctrl_wr) |=> irq_o);

  p_irq_holds_r6: assert property (@(posedge clk_ref_i) disable iff (!rst_n_i)
    (irq_o && !ack_pulse && !ctrl_wr) |=> irq_o);

  p_ack_drops_irq_r4: assert property (@(posedge clk_ref_i) disable iff (!rst_n_i)
    (ack_pulse && !tick) |=> !irq_o);
endmodule

// File: tb/test_clk_slow_detect.sv
`timescale 1ns/1ps
module test_clk_slow_detect;
  localparam int unsigned REF_NS    = 10;
  localparam int unsigned TIME_DIV  = 10000;
  localparam int          TIMER_EXP = 100_000_000 / (REF_NS * TIME_DIV);

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       int_clk = 1'b0;
  logic       ext_clk = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [5:0] wr_data = '0;
  logic       slow_flag, irq;

  int int_half = 0;
  int ext_half = 0;
  int n_tests = 0;
  int n_fail = 0;
  int cyc = 0;

  typedef struct { string req; logic val; } exp_t;
  exp_t exp_q[$];

  clk_slow_detect #(.REF_NS(REF_NS), .TIME_DIV(TIME_DIV)) i_clk_slow_detect (
    .clk_ref_i(clk), .rst_n_i(rst_n), .int_clk_i(int_clk), .ext_clk_i(ext_clk),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .slow_flag_o(slow_flag), .irq_o(irq));

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // measured clocks, offset by 1 ns so their edges never meet a reference edge
  initial begin
    #1;
    forever begin
      if (int_half == 0) begin int_clk = 1'b0; #10; end
      else begin #(int_half); int_clk = ~int_clk; end
    end
  end
  initial begin
    #1;
    forever begin
      if (ext_half == 0) begin ext_clk = 1'b0; #10; end
      else begin #(ext_half); ext_clk = ~ext_clk; end
    end
  end

  task automatic check(input string req, input int act, input int expv, input string what);
    n_tests++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // monitor: on each interrupt rise, pop one expected flag value and compare
  logic irq_prev = 1'b0;
  always @(negedge clk) begin
    if (irq && !irq_prev && exp_q.size() > 0) begin
      exp_t it;
      it = exp_q.pop_front();
      check(it.req, int'(slow_flag), int'(it.val), "slow flag at interrupt");
    end
    irq_prev = irq;
  end

  task automatic wr(input logic [3:0] a, input logic [5:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_irq_ack();
    while (!irq) @(negedge clk);
    wr(4'h4, 6'h00);
  endtask

  // driver: configure, resynchronise to the timer, push the expected verdict
  task automatic run_case(input string req, input int rng, input int ihalf, input logic expv);
    int_half = ihalf;
    wr(4'h2, 6'(rng));
    wait_irq_ack();
    exp_q.push_back('{req, expv});
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  initial begin
    int t1, t2;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", int'(slow_flag), 0, "flag after reset");
    check("R10", int'(irq), 0, "irq after reset");

    // R6: the timer elapses while masked, then unmasking releases the pending interrupt
    repeat (1200) @(negedge clk);
    check("R6", int'(irq), 0, "irq while masked");
    wr(4'h3, 6'h01);
    check("R6", int'(irq), 1, "irq after unmask");

    wr(4'h1, 6'h3E);                      // internal source
    run_case("R2", 5, 100, 1'b0);         // 1 us window, 200 ns clock
    run_case("R3", 5, 2000, 1'b1);        // 1 us window, 4 us clock

    // R4: flag stays set without an acknowledge even with a fast clock
    int_half = 100;
    repeat (300) @(negedge clk);
    check("R4", int'(slow_flag), 1, "flag sticky before ack");
    wr(4'h4, 6'h00);
    check("R4", int'(slow_flag), 0, "flag after ack");
    check("R4", int'(irq), 0, "irq after ack");

    run_case("R1", 2, 15, 1'b0);          // 100 ns window, 30 ns clock
    run_case("R1", 2, 100, 1'b1);         // 100 ns window, 200 ns clock
    run_case("R1", 7, 15, 1'b0);          // 1 ms scaled to 10 cycles
    run_case("R1", 0, 100, 1'b1);         // 20 ns window
    run_case("R1", 9, 0, 1'b0);           // 1 s scaled beyond the timer interval

    // R9: an invalid code leaves the 1 us range active
    wr(4'h2, 6'h05);
    run_case("R9", 12, 0, 1'b1);
    wr(4'h2, 6'h0F);
    run_case("R9", 15, 0, 1'b1);

    // R7: source selection
    ext_half = 100;
    run_case("R7", 5, 0, 1'b1);           // internal stopped
    wr(4'h1, 6'h3F);
    run_case("R7", 5, 0, 1'b0);           // external running
    wr(4'h1, 6'h1E);
    run_case("R7", 5, 0, 1'b0);
    wr(4'h1, 6'h3E);
    run_case("R7", 5, 0, 1'b1);

    // R8: repeated range writes keep a 100-cycle window from ever completing
    int_half = 0;
    wr(4'h2, 6'h05);
    wait_irq_ack();
    exp_q.push_back('{"R8", 1'b0});
    for (int k = 0; k < 30; k++) begin
      wr(4'h2, 6'h05);
      repeat (60) @(negedge clk);
    end
    while (exp_q.size() != 0) @(negedge clk);

    // R5: interrupt rise to rise spacing
    wait_irq_ack();
    while (!irq) @(negedge clk);
    t1 = cyc;
    wr(4'h4, 6'h00);
    while (!irq) @(negedge clk);
    t2 = cyc;
    check("R5", t2 - t1, TIMER_EXP, "timer interval in cycles");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule